// File: doc/BRIEF.md
# Fractional High/Low-Count Clock Divider

This block derives a slower square wave from a fast reference clock. Every output period is built from a high phase followed by a low phase. The length of each phase is a whole number of reference ticks. The division ratio has two parts: an integer part and a fraction given as a numerator over a denominator. When the fraction is non-zero, an accumulator decides, one period at a time, whether that period lasts the integer count or one tick longer. Over many periods the average length then matches the requested ratio.

A separate one-shot correction strobe lengthens the low phase of the next period by one tick. An external timing loop can use it to nudge the output back into step without reprogramming the ratio. The output is a registered level that a downstream consumer can use as a clock enable or a divided clock.

Top module: `frac_clkdiv`

## Requirements
- R1: While `rst` is high, or whenever `en` was low at the previous reference edge, `clk_out` is 0. Disabling or resetting clears the phase counters, the fraction accumulator and any pending correction.
- R2: In the first cycle after `en` goes high from the idle state, `clk_out` is 1, so the output always begins with a high phase.
- R3: With a zero fraction, every period has the same length, `int_part` ticks. The high phase lasts floor(`int_part`/2) ticks and the low phase lasts the remainder. A ratio of 4 gives 2 high and 2 low; a ratio of 3 gives 1 high and 2 low.
- R4: The smallest division is 2, which gives 1 tick high and 1 tick low. An `int_part` below 2 is treated as 2.
- R5: When `frac_num` < `frac_den`, each period adds `frac_num` to an accumulator that starts at 0. If the sum reaches `frac_den`, that period lasts `int_part`+1 ticks and `frac_den` is subtracted. When `frac_num` >= `frac_den`, the fraction is ignored.
- R6: When a period has an odd tick count, the high phase takes floor(total/2) ticks and the low phase takes the rest. The high phase is therefore never longer than the low phase that follows it.
- R7: The ratio inputs are sampled only in the cycle a period begins. A change made part-way through a period takes effect from the next period.
- R8: A correction strobe that is high on a reference edge inside a period lengthens the low phase of the next period by exactly one tick. The integer part and the fraction sequence are unaffected.
- R9: Several correction strobes that arrive before the next period begins merge into one, so at most one extra tick is added to any period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the output low and clears state |
| int_part | input | INT_W | Integer part of the division ratio (values below 2 act as 2) |
| frac_num | input | FRAC_W | Fraction numerator |
| frac_den | input | FRAC_W | Fraction denominator |
| corr_stb | input | 1 | One-tick correction request |
| clk_out | output | 1 | Divided square-wave output |

## Verification
On every cycle, the checker confirms three things: the output stays low under reset or disable, a high phase follows enable at once, and a ratio of 2 or less always gives a single-tick high phase. It also confirms that each high phase is no longer than the low phase after it. The exact fractional sequence is shown only by the bench scenarios, which compare each period's high and low lengths against an independent accumulator model. The same applies to the point at which a mid-period ratio change takes effect, and to the merging of repeated correction strobes into a single extra tick.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int TICK_W = 16;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        tick_t hi;
        tick_t lo;
    } span_t;

    // Splits one period into high and low tick counts.
    function automatic span_t split_period(tick_t base, logic carry, logic extra);
        tick_t total;
        span_t s;
        total = ((base < tick_t'(2)) ? tick_t'(2) : base) + tick_t'(carry);
        s.hi  = total >> 1;
        s.lo  = total - s.hi + tick_t'(extra);
        return s;
    endfunction

endpackage

// File: rtl/fcd_frac_acc.sv
module fcd_frac_acc #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    output logic              carry
);
    localparam int ACC_W = FRAC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic             frac_ok;

    always_comb begin
        frac_ok = (num < den);
        sum     = acc + {1'b0, num};
        carry   = frac_ok && (sum >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (step && frac_ok) begin
            acc <= carry ? (sum - {1'b0, den}) : sum;
        end
    end

endmodule

// File: rtl/fcd_corr_latch.sv
module fcd_corr_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stb,
    input  logic take,
    output logic extra
);
    logic pend;

    assign extra = pend | stb;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= 1'b0;
        end else if (take) begin
            pend <= 1'b0;
        end else if (stb) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/fcd_phase_gen.sv
module fcd_phase_gen
    import fcd_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INT_W-1:0] int_part,
    input  logic             carry,
    input  logic             extra,
    output logic             start,
    output logic             clk_out
);
    phase_e ph;
    tick_t  cnt;
    tick_t  lo_hold;
    span_t  span;

    always_comb begin
        span  = split_period(tick_t'(int_part), carry, extra);
        start = en && ((ph == PH_IDLE) || ((ph == PH_LOW) && (cnt == '0)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            lo_hold <= '0;
        end else if (start) begin
            ph      <= PH_HIGH;
            cnt     <= span.hi - tick_t'(1);
            lo_hold <= span.lo;
        end else if (cnt != '0) begin
            cnt <= cnt - tick_t'(1);
        end else if (ph == PH_HIGH) begin
            ph  <= PH_LOW;
            cnt <= lo_hold - tick_t'(1);
        end
    end

    assign clk_out = (ph == PH_HIGH);

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic              corr_stb,
    output logic              clk_out
);
    logic start;
    logic carry;
    logic extra;
    logic clr;

    assign clr = !en;

    fcd_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (start),
        .num  (frac_num),
        .den  (frac_den),
        .carry(carry)
    );

    fcd_corr_latch u_corr (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .stb  (corr_stb),
        .take (start),
        .extra(extra)
    );

    fcd_phase_gen #(.INT_W(INT_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .int_part(int_part),
        .carry   (carry),
        .extra   (extra),
        .start   (start),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int INT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [INT_W-1:0] int_part,
    input logic             clk_out
);
    logic        prev_out;
    logic        seen_fall;
    logic [15:0] hi_cnt;
    logic [15:0] hi_done;
    logic [15:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev_out  <= 1'b0;
            seen_fall <= 1'b0;
            hi_cnt    <= '0;
            hi_done   <= '0;
            lo_cnt    <= '0;
        end else begin
            prev_out <= clk_out;
            if (clk_out && !prev_out) begin
                hi_cnt <= 16'd1;
            end else if (clk_out) begin
                hi_cnt <= hi_cnt + 16'd1;
            end
            if (!clk_out && prev_out) begin
                hi_done   <= hi_cnt;
                lo_cnt    <= 16'd1;
                seen_fall <= 1'b1;
            end else if (!clk_out) begin
                lo_cnt <= lo_cnt + 16'd1;
            end
        end
    end

    assert_reset_R1: assert property (@(posedge clk) rst |=> !clk_out);

    assert_disable_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !clk_out);

    assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> clk_out);

    assert_min_div_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_out) && ($past(int_part) <= INT_W'(2))) |=> !clk_out);

    assert_split_R6: assert property (@(posedge clk) disable iff (rst || !en)
        (clk_out && !prev_out && seen_fall) |-> (lo_cnt >= hi_done));

endmodule

bind frac_clkdiv fcd_checker #(.INT_W(INT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .int_part(int_part),
    .clk_out (clk_out)
);

// File: tb/tb_frac_clkdiv.sv
module tb_frac_clkdiv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] int_part = 8'd4;
    logic [7:0] frac_num = 8'd0;
    logic [7:0] frac_den = 8'd1;
    logic       corr_stb = 1'b0;
    logic       clk_out;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int m_acc = 0;
    int h, l, eh, el, sum;

    localparam int NV = 9;
    // integer part, numerator, denominator, expected ticks over 10 periods
    localparam int VI  [NV] = '{2, 4, 3, 4, 8, 5, 7, 1, 6};
    localparam int VF  [NV] = '{0, 0, 0, 4, 0, 1, 2, 0, 5};
    localparam int VD  [NV] = '{1, 1, 1, 5, 1, 3, 3, 1, 5};
    localparam int VSUM[NV] = '{20, 40, 30, 48, 80, 53, 76, 20, 60};

    frac_clkdiv dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .int_part(int_part),
        .frac_num(frac_num),
        .frac_den(frac_den),
        .corr_stb(corr_stb),
        .clk_out (clk_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic model_next(int ip, int fn, int fd, bit corr, output int mh, output int ml);
        int tot;
        tot = (ip < 2) ? 2 : ip;
        if (fn < fd) begin
            m_acc += fn;
            if (m_acc >= fd) begin
                m_acc -= fd;
                tot++;
            end
        end
        mh = tot / 2;
        ml = tot - mh + (corr ? 1 : 0);
    endtask

    task automatic meas(output int mh, output int ml);
        mh = 0;
        ml = 0;
        while (clk_out) begin
            mh++;
            @(negedge clk);
        end
        while (!clk_out) begin
            ml++;
            @(negedge clk);
        end
    endtask

    task automatic restart(int ip, int fn, int fd);
        @(negedge clk);
        en = 1'b0;
        int_part = 8'(ip);
        frac_num = 8'(fn);
        frac_den = 8'(fd);
        @(negedge clk);
        @(negedge clk);
        check(clk_out == 1'b0, "R1 idle output low", int'(clk_out), 0);
        m_acc = 0;
        en = 1'b1;
        @(negedge clk);
        check(clk_out == 1'b1, "R2 first phase high", int'(clk_out), 1);
    endtask

    task automatic cmp_period(string tag, int ah, int al, int xh, int xl);
        check(ah == xh, {tag, " high ticks"}, ah, xh);
        check(al == xl, {tag, " low ticks"}, al, xl);
    endtask

    initial begin
        // R1: output low under reset, even with enable high
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(clk_out == 1'b0, "R1 low in reset", int'(clk_out), 0);
        rst = 1'b0;
        en = 1'b0;

        // R3 R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            restart(VI[v], VF[v], VD[v]);
            sum = 0;
            for (int p = 0; p < 10; p++) begin
                meas(h, l);
                model_next(VI[v], VF[v], VD[v], 1'b0, eh, el);
                cmp_period($sformatf("R3 R5 R6 vec%0d per%0d", v, p), h, l, eh, el);
                sum += h + l;
            end
            check(sum == VSUM[v], $sformatf("R5 vec%0d total ticks", v), sum, VSUM[v]);
        end

        // R7: ratio change mid-period applies from the next period
        restart(8, 0, 1);
        fork
            meas(h, l);
            begin
                @(negedge clk);
                @(negedge clk);
                int_part = 8'd6;
            end
        join
        cmp_period("R7 period in progress", h, l, 4, 4);
        meas(h, l);
        cmp_period("R7 next period", h, l, 3, 3);

        // R8: correction stretches the next low phase, fraction sequence intact
        restart(4, 4, 5);
        fork
            meas(h, l);
            begin
                corr_stb = 1'b1;
                @(negedge clk);
                corr_stb = 1'b0;
            end
        join
        model_next(4, 4, 5, 1'b0, eh, el);
        cmp_period("R8 strobe period", h, l, eh, el);
        meas(h, l);
        model_next(4, 4, 5, 1'b1, eh, el);
        cmp_period("R8 stretched period", h, l, eh, el);
        for (int p = 0; p < 4; p++) begin
            meas(h, l);
            model_next(4, 4, 5, 1'b0, eh, el);
            cmp_period("R8 later period", h, l, eh, el);
        end

        // R9: two strobes in one period add a single tick
        restart(8, 0, 1);
        fork
            meas(h, l);
            begin
                corr_stb = 1'b1;
                @(negedge clk);
                corr_stb = 1'b0;
                @(negedge clk);
                corr_stb = 1'b1;
                @(negedge clk);
                corr_stb = 1'b0;
            end
        join
        cmp_period("R9 strobe period", h, l, 4, 4);
        meas(h, l);
        cmp_period("R9 merged stretch", h, l, 4, 5);
        meas(h, l);
        cmp_period("R9 after stretch", h, l, 4, 4);

        // R1: disable mid-run drops output and clears the accumulator
        restart(4, 4, 5);
        for (int p = 0; p < 3; p++) begin
            meas(h, l);
            model_next(4, 4, 5, 1'b0, eh, el);
            cmp_period("R5 before disable", h, l, eh, el);
        end
        en = 1'b0;
        @(negedge clk);
        check(clk_out == 1'b0, "R1 low after disable", int'(clk_out), 0);
        restart(4, 4, 5);
        for (int p = 0; p < 5; p++) begin
            meas(h, l);
            model_next(4, 4, 5, 1'b0, eh, el);
            cmp_period("R1 accumulator cleared", h, l, eh, el);
        end

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(clk_out == 1'b0, "R1 low after reset", int'(clk_out), 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule